// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Comparison Flags

This block is a small two's-complement arithmetic logic unit built as a row of identical one-bit slices. Each slice can invert either of its operand bits, then forms the AND, the OR or the full-adder sum of the two conditioned bits. A carry ripples from the least significant slice upward. Four control lines drive every slice in common: an invert-A line, a negate-B line and a two-bit operation select. The negate-B line also feeds the carry into the lowest slice, so that the adder sees the two's-complement negation of B.

Next to the result the unit reports zero, sign, carry and overflow conditions. It also gives a signed less-than flag that stays correct when the subtraction overflows, and an equality flag built only from a NOR of the result bits. The design is purely combinational. Its width is a parameter, and its default is four bits, which covers operands from -8 to 7.

Top module: `alu_bitslice`

## Requirements
- R1: With op_sel = 2'b10 (add), inv_a = 0 and neg_b = 0, result equals (a_in + b_in) mod 2^WIDTH.
- R2: With op_sel = 2'b10, inv_a = 0 and neg_b = 1, result equals (a_in - b_in) mod 2^WIDTH. Every slice sees the bit-inverted B and a carry-in of 1 at the lowest slice.
- R3: With op_sel = 2'b00, result is the bitwise AND of the conditioned operands. With op_sel = 2'b01, it is their bitwise OR. The conditioned A is ~a_in when inv_a = 1, else a_in. The conditioned B is ~b_in when neg_b = 1, else b_in.
- R4: With op_sel = 2'b11 (reserved), result is all zeros whatever the other inputs are.
- R5: flag_zero is 1 exactly when every result bit is 0.
- R6: flag_sign equals the most significant result bit.
- R7: flag_carry equals the carry out of the most significant slice when op_sel = 2'b10, and is 0 for every other op_sel.
- R8: flag_ovf is 1 when op_sel = 2'b10 and the signed sum of the conditioned operands plus the carry-in does not fit in WIDTH bits. It is 0 for every other op_sel.
- R9: In subtract mode (op_sel = 2'b10, inv_a = 0, neg_b = 1), flag_lt is 1 exactly when signed a_in < signed b_in, overflow included. Outside subtract mode it is 0.
- R10: In subtract mode, flag_eq is 1 exactly when a_in equals b_in. Outside subtract mode it is 0.
- R11: With op_sel = 2'b10, inv_a = 1 and neg_b = 1, result equals (-a_in - b_in - 1) mod 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | Operand A, two's complement |
| b_in | input | WIDTH | Operand B, two's complement |
| inv_a | input | 1 | Inverts A in every slice |
| neg_b | input | 1 | Inverts B in every slice and sets the lowest carry-in |
| op_sel | input | 2 | 00 AND, 01 OR, 10 add, 11 reserved (zero) |
| result | output | WIDTH | Slice outputs |
| flag_zero | output | 1 | Result is all zeros |
| flag_sign | output | 1 | Result MSB |
| flag_carry | output | 1 | MSB carry out during add |
| flag_ovf | output | 1 | Signed overflow during add |
| flag_lt | output | 1 | Signed A < B in subtract mode |
| flag_eq | output | 1 | A equals B in subtract mode |

## Verification
The checker re-derives, on every input change, the signed less-than and equality answers in subtract mode. It also checks that the reserved operation yields zero, that the add result matches modular arithmetic and that the carry and overflow flags stay low outside add. These are the properties where a wrong carry chain or a missing overflow correction shows first. Whether each inversion reaches the AND and OR paths, and the exact values of the flags for every control combination, are shown by the bench's full sweep of all control settings against all operand pairs.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;
   typedef enum logic [1:0] {
      OP_AND  = 2'b00,
      OP_OR   = 2'b01,
      OP_ADD  = 2'b10,
      OP_RSVD = 2'b11
   } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
   import alu_bitslice_pkg::*;
(
   input  logic    a_bit,
   input  logic    b_bit,
   input  logic    inv_a,
   input  logic    inv_b,
   input  logic    c_in,
   input  alu_op_e op,
   output logic    r_bit,
   output logic    c_out
);
   logic a_c, b_c, sum;

   always_comb begin
      a_c   = inv_a ? ~a_bit : a_bit;
      b_c   = inv_b ? ~b_bit : b_bit;
      sum   = a_c ^ b_c ^ c_in;
      c_out = (a_c & b_c) | (c_in & (a_c | b_c));
      unique case (op)
         OP_AND:  r_bit = a_c & b_c;
         OP_OR:   r_bit = a_c | b_c;
         OP_ADD:  r_bit = sum;
         default: r_bit = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_bitslice_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] res,
   input  logic             c_msb_in,
   input  logic             c_msb_out,
   input  alu_op_e          op,
   input  logic             inv_a,
   input  logic             neg_b,
   output logic             zero,
   output logic             sign,
   output logic             carry,
   output logic             ovf,
   output logic             lt,
   output logic             eq
);
   logic is_add, is_sub, ovf_raw;

   always_comb begin
      is_add  = (op == OP_ADD);
      is_sub  = is_add & neg_b & ~inv_a;
      zero    = ~|res;
      sign    = res[WIDTH-1];
      ovf_raw = c_msb_in ^ c_msb_out;
      carry   = is_add & c_msb_out;
      ovf     = is_add & ovf_raw;
      lt      = is_sub & (sign ^ ovf_raw);
      eq      = is_sub & zero;
   end
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
   import alu_bitslice_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             inv_a,
   input  logic             neg_b,
   input  logic [1:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_zero,
   output logic             flag_sign,
   output logic             flag_carry,
   output logic             flag_ovf,
   output logic             flag_lt,
   output logic             flag_eq
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_bitslice: WIDTH must be at least 2");
   end

   alu_op_e          op;
   logic [WIDTH:0]   chain;

   assign op       = alu_op_e'(op_sel);
   assign chain[0] = neg_b;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_slice u_slice (
         .a_bit (a_in[i]),
         .b_bit (b_in[i]),
         .inv_a (inv_a),
         .inv_b (neg_b),
         .c_in  (chain[i]),
         .op    (op),
         .r_bit (result[i]),
         .c_out (chain[i+1])
      );
   end

   alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
      .res       (result),
      .c_msb_in  (chain[MSB]),
      .c_msb_out (chain[WIDTH]),
      .op        (op),
      .inv_a     (inv_a),
      .neg_b     (neg_b),
      .zero      (flag_zero),
      .sign      (flag_sign),
      .carry     (flag_carry),
      .ovf       (flag_ovf),
      .lt        (flag_lt),
      .eq        (flag_eq)
   );
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
   parameter int WIDTH = 4
) (
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic             inv_a,
   input logic             neg_b,
   input logic [1:0]       op_sel,
   input logic [WIDTH-1:0] result,
   input logic             flag_zero,
   input logic             flag_carry,
   input logic             flag_ovf,
   input logic             flag_lt,
   input logic             flag_eq
);
   logic sub_mode;
   logic [WIDTH-1:0] diff, sum;

   always_comb begin
      sub_mode = (op_sel == 2'b10) && neg_b && !inv_a;
      diff     = a_in - b_in;
      sum      = a_in + b_in;

      assert_sub_lt_R9: assert (!sub_mode ||
         (flag_lt == ($signed(a_in) < $signed(b_in))))
         else $error("R9 less-than mismatch");
      assert_sub_eq_R10: assert (!sub_mode || (flag_eq == (a_in == b_in)))
         else $error("R10 equality mismatch");
      assert_sub_res_R2: assert (!sub_mode || (result == diff))
         else $error("R2 difference mismatch");
      assert_add_res_R1: assert (!((op_sel == 2'b10) && !neg_b && !inv_a) ||
         (result == sum))
         else $error("R1 sum mismatch");
      assert_rsvd_zero_R4: assert (op_sel != 2'b11 || (result == '0 && flag_zero))
         else $error("R4 reserved op not zero");
      assert_quiet_flags_R7: assert (op_sel == 2'b10 || (!flag_carry && !flag_ovf))
         else $error("R7/R8 carry or overflow outside add");
      assert_no_cmp_R10: assert (sub_mode || (!flag_lt && !flag_eq))
         else $error("R9/R10 compare flag outside subtract");
   end
endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) chk_i (
   .a_in       (a_in),
   .b_in       (b_in),
   .inv_a      (inv_a),
   .neg_b      (neg_b),
   .op_sel     (op_sel),
   .result     (result),
   .flag_zero  (flag_zero),
   .flag_carry (flag_carry),
   .flag_ovf   (flag_ovf),
   .flag_lt    (flag_lt),
   .flag_eq    (flag_eq)
);

// File: tb/alu_bitslice_tb_top.sv
`timescale 1ns/1ps
module alu_bitslice_tb_top;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         inv_a = 1'b0, neg_b = 1'b0;
   logic [1:0]   op_sel = 2'b11;
   logic [W-1:0] result;
   logic         flag_zero, flag_sign, flag_carry, flag_ovf, flag_lt, flag_eq;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   alu_bitslice #(.WIDTH(W)) dut_i (
      .a_in(a_in), .b_in(b_in), .inv_a(inv_a), .neg_b(neg_b), .op_sel(op_sel),
      .result(result), .flag_zero(flag_zero), .flag_sign(flag_sign),
      .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_lt(flag_lt),
      .flag_eq(flag_eq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s a=%0d b=%0d inv_a=%0b neg_b=%0b op=%0d actual=%0d expected=%0d",
                  req, a_in, b_in, inv_a, neg_b, op_sel, act, exp);
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reserved op at start gives zero result and zero flag
      check("R4 reset-state result", int'(result), 0);
      check("R5 reset-state zero", int'(flag_zero), 1);

      for (int ctl = 0; ctl < 16; ctl++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               int ac, bc, cin, s5, er, ec, eo, sa, sb, elt, eeq;
               bit is_add, is_sub;
               @(posedge clk);
               op_sel = ctl[1:0];
               inv_a  = ctl[2];
               neg_b  = ctl[3];
               a_in   = a[3:0];
               b_in   = b[3:0];
               @(negedge clk);
               ac  = inv_a ? (15 - a) : a;
               bc  = neg_b ? (15 - b) : b;
               cin = neg_b ? 1 : 0;
               s5  = ac + bc + cin;
               is_add = (ctl[1:0] == 2);
               is_sub = is_add && neg_b && !inv_a;
               case (ctl[1:0])
                  0: er = ac & bc;
                  1: er = ac | bc;
                  2: er = s5 % 16;
                  default: er = 0;
               endcase
               ec = is_add ? (s5 / 16) : 0;
               sa = (ac > 7) ? ac - 16 : ac;
               sb = (bc > 7) ? bc - 16 : bc;
               eo = (is_add && ((sa + sb + cin) > 7 || (sa + sb + cin) < -8)) ? 1 : 0;
               elt = (is_sub && (((a > 7) ? a - 16 : a) < ((b > 7) ? b - 16 : b))) ? 1 : 0;
               eeq = (is_sub && a == b) ? 1 : 0;

               if (ctl[1:0] == 2 && !inv_a && !neg_b) check("R1 sum", int'(result), er);
               else if (is_sub) check("R2 difference", int'(result), (a - b + 16) % 16);
               else if (ctl[1:0] < 2) check("R3 and/or", int'(result), er);
               else if (ctl[1:0] == 3) check("R4 reserved", int'(result), 0);
               else if (inv_a && neg_b) check("R11 -A-B-1", int'(result), (32 - a - b - 1) % 16);
               else check("R3 inverted-A add", int'(result), er);
               check("R5 zero", int'(flag_zero), (er == 0) ? 1 : 0);
               check("R6 sign", int'(flag_sign), er / 8);
               check("R7 carry", int'(flag_carry), ec);
               check("R8 overflow", int'(flag_ovf), eo);
               check("R9 less-than", int'(flag_lt), elt);
               check("R10 equality", int'(flag_eq), eeq);
            end
         end
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule